// File: doc/BRIEF.md
# Key-Sequenced Watchdog Counter

This block is a watchdog counter that sits on a simple 32-bit register bus. Software cannot start or stop it with a single write. To start it, two fixed key values must be written back to back to a dedicated key register. To stop it, a different pair must be written the same way. Any stray value in the middle of a pair cancels that pair. The counter counts up on a free-running 32768 Hz tick-enable input. An optional power-of-two prescaler can divide that rate by up to 128. When the counter rolls over from all ones, it reloads from a load register and pulses the timeout reset output.

The key register only records the last value written. Reading it does not show whether the timer is running. The run state shows only in the counter: while stopped, its value does not change between reads. While the counter runs, the prescaler settings are frozen, so a running watchdog cannot be slowed down by rewriting them.

Top module: `wdog_keyed_top`

## Requirements
- R1: Writing 0x0000BBBB and then 0x00004444 to the key register, as two consecutive key-register writes, starts the counter. From the next tick on, the counter advances.
- R2: Writing 0x0000AAAA and then 0x00005555 to the key register, as two consecutive key-register writes, stops the counter. Later ticks leave its value unchanged.
- R3: A 0x00004444 (or 0x00005555) write that does not directly follow its opening key changes no run state. Any other value written between the two keys of a pair cancels that pair.
- R4: The key register (offset 0x0C) reads back the last full 32-bit value written to it, whether or not that write changed the run state. After reset it reads 0x00005555.
- R5: Control bit 5 enables the prescaler, and control bits 4:2 hold an exponent e. With the prescaler enabled, the counter advances once every 2^e ticks. With it disabled, the counter advances on every tick. The prescale phase restarts at zero whenever the counter is stopped.
- R6: The counter register (offset 0x04) can be read at any time. It changes on ticks only while the counter runs. It can be written at any time, and a bus write takes priority over a tick in the same cycle.
- R7: The control register (offset 0x00) resets to zero and keeps only bits 5:2, with all other bits reading zero. Writes to it are ignored while the counter runs.
- R8: When the counter advances from 0xFFFFFFFF, it takes the value of the load register (offset 0x08, read/write, reset zero). The timeout output is high for exactly that one cycle.
- R9: A read or write to any address other than 0x00, 0x04, 0x08 or 0x0C returns read data zero and raises the error flag for one cycle. Mapped accesses leave the flag low.
- R10: Read data and the error flag are registered. They are valid in the cycle after the access and hold until the next access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 32 | Registered read data |
| bus_err | output | 1 | Registered one-cycle error for an unmapped access |
| tick_32k | input | 1 | One-cycle enable at the 32768 Hz count rate |
| wdt_rst_o | output | 1 | One-cycle timeout reset pulse |

## Verification
The bench goes after the key sequences most likely to be decoded loosely. These are a lone second key, a pair broken by an unrelated value, and a stop pair broken the same way. A checker that remembered a first key too long would start or stop the timer on any of these. It also confirms that the key register reads the closing start key while the timer is plainly not counting. A design that tied the readback to the run state would fail that check. The prescaler is measured at exponents 0 and 2, and the control freeze is tested by a rewrite while running. A miscounted divider or a missing freeze shows up as a wrong counter value. The rollover test watches the cycle before and the cycle after the timeout. An off-by-one compare or a stretched pulse would fail there.

// File: rtl/wdog_keyed_pkg.sv
package wdog_keyed_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;
    localparam int EXP_W  = 3;
    localparam int DIV_W  = (1 << EXP_W) - 1;

    localparam logic [ADDR_W-1:0] OFF_CTRL  = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_COUNT = 8'h04;
    localparam logic [ADDR_W-1:0] OFF_LOAD  = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_KEY   = 8'h0C;

    localparam logic [DATA_W-1:0] KEY_ARM_START = 32'h0000_BBBB;
    localparam logic [DATA_W-1:0] KEY_FIRE_START = 32'h0000_4444;
    localparam logic [DATA_W-1:0] KEY_ARM_STOP  = 32'h0000_AAAA;
    localparam logic [DATA_W-1:0] KEY_FIRE_STOP = 32'h0000_5555;
    localparam logic [DATA_W-1:0] KEY_RESET_VAL = KEY_FIRE_STOP;

    localparam int CTRL_EXP_LSB = 2;
    localparam int CTRL_EN_BIT  = 5;

    typedef enum logic [1:0] {
        KS_IDLE,
        KS_ARMED_START,
        KS_ARMED_STOP
    } key_state_t;

    typedef enum logic [2:0] {
        SEL_CTRL,
        SEL_COUNT,
        SEL_LOAD,
        SEL_KEY,
        SEL_NONE
    } reg_sel_t;

    typedef struct packed {
        logic             pre_en;
        logic [EXP_W-1:0] pre_exp;
    } ctrl_t;

    function automatic reg_sel_t decode_addr(input logic [ADDR_W-1:0] a);
        case (a)
            OFF_CTRL:  return SEL_CTRL;
            OFF_COUNT: return SEL_COUNT;
            OFF_LOAD:  return SEL_LOAD;
            OFF_KEY:   return SEL_KEY;
            default:   return SEL_NONE;
        endcase
    endfunction

    function automatic ctrl_t ctrl_from_word(input logic [DATA_W-1:0] w);
        ctrl_t c;
        c.pre_en  = w[CTRL_EN_BIT];
        c.pre_exp = w[CTRL_EXP_LSB +: EXP_W];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_to_word(input ctrl_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[CTRL_EN_BIT] = c.pre_en;
        w[CTRL_EXP_LSB +: EXP_W] = c.pre_exp;
        return w;
    endfunction

endpackage

// File: rtl/wdog_key_seq.sv
module wdog_key_seq
    import wdog_keyed_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              key_we,
    input  logic [DATA_W-1:0] key_wdata,
    output logic              run_o,
    output logic [DATA_W-1:0] key_q_o
);

    key_state_t        state_q;
    logic              run_q;
    logic [DATA_W-1:0] key_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= KS_IDLE;
            run_q   <= 1'b0;
            key_q   <= KEY_RESET_VAL;
        end else if (key_we) begin
            key_q <= key_wdata;
            if (key_wdata == KEY_ARM_START) begin
                state_q <= KS_ARMED_START;
            end else if (key_wdata == KEY_ARM_STOP) begin
                state_q <= KS_ARMED_STOP;
            end else begin
                state_q <= KS_IDLE;
                if (state_q == KS_ARMED_START && key_wdata == KEY_FIRE_START)
                    run_q <= 1'b1;
                else if (state_q == KS_ARMED_STOP && key_wdata == KEY_FIRE_STOP)
                    run_q <= 1'b0;
            end
        end
    end

    assign run_o   = run_q;
    assign key_q_o = key_q;

    // R1: a start only ever follows a closing start key write
    assert_start_by_key_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(run_q) |-> $past(key_we && key_wdata == KEY_FIRE_START));

    // R2: a stop only ever follows a closing stop key write
    assert_stop_by_key_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(run_q) |-> $past(key_we && key_wdata == KEY_FIRE_STOP));

    // R3: without a key write the run state holds
    assert_run_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !key_we |=> $stable(run_q));

    // R4: key readback follows the written value
    assert_key_readback_R4: assert property (@(posedge clk) disable iff (rst)
        key_we |=> key_q == $past(key_wdata));

endmodule

// File: rtl/wdog_prescale.sv
module wdog_prescale
    import wdog_keyed_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  run,
    input  logic  tick,
    input  ctrl_t cfg,
    output logic  step_o
);

    logic [DIV_W-1:0] phase_q;
    logic [DIV_W-1:0] mask;
    logic             wrap;

    always_comb begin
        for (int i = 0; i < DIV_W; i++)
            mask[i] = (i < int'(cfg.pre_exp));
    end

    assign wrap   = ((phase_q & mask) == mask);
    assign step_o = run && tick && (!cfg.pre_en || wrap);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            phase_q <= '0;
        end else if (tick) begin
            if (!cfg.pre_en || wrap)
                phase_q <= '0;
            else
                phase_q <= phase_q + 1'b1;
        end
    end

    // R5: the divider phase is parked at zero while stopped
    assert_phase_park_R5: assert property (@(posedge clk) disable iff (rst)
        !run |=> phase_q == '0);

    // R5: no step without a tick
    assert_step_needs_tick_R5: assert property (@(posedge clk) disable iff (rst)
        step_o |-> tick && run);

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
    import wdog_keyed_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] load_val,
    output logic [DATA_W-1:0] count_o,
    output logic              timeout_o
);

    logic [DATA_W-1:0] count_q;
    logic              timeout_q;
    logic              at_top;

    assign at_top = (count_q == {DATA_W{1'b1}});

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q   <= '0;
            timeout_q <= 1'b0;
        end else begin
            timeout_q <= 1'b0;
            if (wr_en) begin
                count_q <= wr_data;
            end else if (step) begin
                if (at_top) begin
                    count_q   <= load_val;
                    timeout_q <= 1'b1;
                end else begin
                    count_q <= count_q + 1'b1;
                end
            end
        end
    end

    assign count_o   = count_q;
    assign timeout_o = timeout_q;

    // R6: without a step or a write the count is frozen
    assert_count_frozen_R6: assert property (@(posedge clk) disable iff (rst)
        !step && !wr_en |=> count_q == $past(count_q));

    // R8: a timeout only ever follows a count of all ones
    assert_timeout_from_top_R8: assert property (@(posedge clk) disable iff (rst)
        timeout_q |-> $past(count_q) == {DATA_W{1'b1}} && $past(step));

endmodule

// File: rtl/wdog_keyed_top.sv
module wdog_keyed_top
    import wdog_keyed_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_err,
    input  logic              tick_32k,
    output logic              wdt_rst_o
);

    reg_sel_t          sel;
    ctrl_t             ctrl_q;
    logic [DATA_W-1:0] load_q;
    logic [DATA_W-1:0] count_w;
    logic [DATA_W-1:0] key_w;
    logic              run_w;
    logic              step_w;
    logic              ctrl_we, count_we, load_we, key_we;
    logic [DATA_W-1:0] rdata_q;
    logic              err_q;
    logic [DATA_W-1:0] rd_mux;

    assign sel      = decode_addr(bus_addr);
    assign ctrl_we  = bus_we && sel == SEL_CTRL;
    assign count_we = bus_we && sel == SEL_COUNT;
    assign load_we  = bus_we && sel == SEL_LOAD;
    assign key_we   = bus_we && sel == SEL_KEY;

    wdog_key_seq u_keys (
        .clk       (clk),
        .rst       (rst),
        .key_we    (key_we),
        .key_wdata (bus_wdata),
        .run_o     (run_w),
        .key_q_o   (key_w)
    );

    wdog_prescale u_pre (
        .clk    (clk),
        .rst    (rst),
        .run    (run_w),
        .tick   (tick_32k),
        .cfg    (ctrl_q),
        .step_o (step_w)
    );

    wdog_counter u_cnt (
        .clk       (clk),
        .rst       (rst),
        .step      (step_w),
        .wr_en     (count_we),
        .wr_data   (bus_wdata),
        .load_val  (load_q),
        .count_o   (count_w),
        .timeout_o (wdt_rst_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            load_q <= '0;
        end else begin
            if (ctrl_we && !run_w)
                ctrl_q <= ctrl_from_word(bus_wdata);
            if (load_we)
                load_q <= bus_wdata;
        end
    end

    always_comb begin
        case (sel)
            SEL_CTRL:  rd_mux = ctrl_to_word(ctrl_q);
            SEL_COUNT: rd_mux = count_w;
            SEL_LOAD:  rd_mux = load_q;
            SEL_KEY:   rd_mux = key_w;
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else begin
            err_q <= (bus_we || bus_re) && sel == SEL_NONE;
            if (bus_re)
                rdata_q <= rd_mux;
        end
    end

    assign bus_rdata = rdata_q;
    assign bus_err   = err_q;

    // R7: control is frozen across a write attempted while running
    assert_ctrl_locked_R7: assert property (@(posedge clk) disable iff (rst)
        run_w && ctrl_we |=> ctrl_q == $past(ctrl_q));

    // R9: an error after a read comes with zero read data
    assert_err_zero_data_R9: assert property (@(posedge clk) disable iff (rst)
        bus_err && $past(bus_re) |-> bus_rdata == '0);

    // R9: the error flag never follows an idle bus cycle
    assert_err_needs_access_R9: assert property (@(posedge clk) disable iff (rst)
        bus_err |-> $past(bus_we || bus_re));

endmodule

// File: tb/wdog_keyed_top_tb.sv
`timescale 1ns/1ps
module wdog_keyed_top_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic        tick_32k = 1'b0;
    logic        wdt_rst_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    wdog_keyed_top u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_re    (bus_re),
        .bus_rdata (bus_rdata),
        .bus_err   (bus_err),
        .tick_32k  (tick_32k),
        .wdt_rst_o (wdt_rst_o)
    );

    localparam logic [7:0] A_CTRL = 8'h00, A_CNT = 8'h04, A_LOAD = 8'h08, A_KEY = 8'h0C;

    task automatic check(input string req, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got 0x%08h expected 0x%08h", req, what, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d, output logic e);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1;
        @(negedge clk);
        bus_re = 1'b0;
        d = bus_rdata;
        e = bus_err;
    endtask

    task automatic tick(output logic to);
        @(negedge clk);
        tick_32k = 1'b1;
        @(negedge clk);
        tick_32k = 1'b0;
        to = wdt_rst_o;
    endtask

    task automatic ticks(input int n);
        logic to;
        for (int i = 0; i < n; i++) tick(to);
    endtask

    task automatic start_seq();
        wr(A_KEY, 32'h0000_BBBB);
        wr(A_KEY, 32'h0000_4444);
    endtask

    task automatic stop_seq();
        wr(A_KEY, 32'h0000_AAAA);
        wr(A_KEY, 32'h0000_5555);
    endtask

    task automatic t_reset();
        logic [31:0] d; logic e;
        rd(A_CTRL, d, e); check("R7", "ctrl after reset", d, 32'h0);
        rd(A_KEY, d, e);  check("R4", "key after reset", d, 32'h5555);
        rd(A_CNT, d, e);  check("R6", "count after reset", d, 32'h0);
        check("R9", "err on mapped read", {31'b0, e}, 32'h0);
        ticks(3);
        rd(A_CNT, d, e);  check("R6", "count stopped over ticks", d, 32'h0);
    endtask

    task automatic t_bad_start();
        logic [31:0] d; logic e;
        wr(A_KEY, 32'h0000_4444);
        ticks(3);
        rd(A_CNT, d, e); check("R3", "lone close key does not start", d, 32'h0);
        rd(A_KEY, d, e); check("R4", "key reads close key while stopped", d, 32'h4444);
        wr(A_KEY, 32'h0000_BBBB);
        wr(A_KEY, 32'h0000_1234);
        wr(A_KEY, 32'h0000_4444);
        ticks(2);
        rd(A_CNT, d, e); check("R3", "broken start pair does not start", d, 32'h0);
    endtask

    task automatic t_start_stop();
        logic [31:0] d; logic e;
        wr(A_CNT, 32'd10);
        start_seq();
        ticks(3);
        rd(A_CNT, d, e); check("R1", "count after start and 3 ticks", d, 32'd13);
        wr(A_CTRL, 32'h0000_003C);
        rd(A_CTRL, d, e); check("R7", "ctrl write ignored while running", d, 32'h0);
        ticks(2);
        rd(A_CNT, d, e); check("R7", "divider unchanged by locked write", d, 32'd15);
        wr(A_KEY, 32'h0000_AAAA);
        wr(A_KEY, 32'h0000_0001);
        wr(A_KEY, 32'h0000_5555);
        ticks(1);
        rd(A_CNT, d, e); check("R3", "broken stop pair keeps running", d, 32'd16);
        stop_seq();
        ticks(4);
        rd(A_CNT, d, e); check("R2", "count frozen after stop", d, 32'd16);
        rd(A_KEY, d, e); check("R4", "key reads last stop key", d, 32'h5555);
    endtask

    task automatic t_prescale();
        logic [31:0] d; logic e;
        wr(A_CTRL, 32'hFFFF_FFFF);
        rd(A_CTRL, d, e); check("R7", "ctrl keeps bits 5:2 only", d, 32'h3C);
        wr(A_CTRL, 32'h0000_0028);
        rd(A_CTRL, d, e); check("R5", "ctrl enable+exp 2", d, 32'h28);
        wr(A_CNT, 32'h0);
        start_seq();
        ticks(8);
        rd(A_CNT, d, e); check("R5", "exp 2: 8 ticks give 2", d, 32'd2);
        ticks(3);
        rd(A_CNT, d, e); check("R5", "exp 2: 3 more ticks give 2", d, 32'd2);
        stop_seq();
        wr(A_CTRL, 32'h0000_0020);
        wr(A_CNT, 32'h0);
        start_seq();
        ticks(3);
        rd(A_CNT, d, e); check("R5", "exp 0 enabled: every tick", d, 32'd3);
        stop_seq();
        wr(A_CTRL, 32'h0);
    endtask

    task automatic t_overflow();
        logic [31:0] d; logic e; logic to;
        wr(A_LOAD, 32'h0000_0100);
        rd(A_LOAD, d, e); check("R8", "load readback", d, 32'h100);
        wr(A_CNT, 32'hFFFF_FFFE);
        start_seq();
        tick(to); check("R8", "no timeout before top", {31'b0, to}, 32'h0);
        tick(to); check("R8", "timeout at rollover", {31'b0, to}, 32'h1);
        @(negedge clk);
        check("R8", "timeout one cycle only", {31'b0, wdt_rst_o}, 32'h0);
        rd(A_CNT, d, e); check("R8", "count reloaded", d, 32'h100);
        stop_seq();
    endtask

    task automatic t_unmapped();
        logic [31:0] d; logic e;
        rd(8'h10, d, e);
        check("R9", "unmapped read data", d, 32'h0);
        check("R9", "unmapped read err", {31'b0, e}, 32'h1);
        check("R10", "err after access", {31'b0, bus_err}, 32'h1);
        @(negedge clk);
        check("R9", "err lasts one cycle", {31'b0, bus_err}, 32'h0);
        wr(8'h44, 32'h1234_5678);
        check("R9", "unmapped write err", {31'b0, bus_err}, 32'h1);
        rd(A_LOAD, d, e);
        check("R10", "read data valid next cycle", d, 32'h100);
        check("R9", "mapped read no err", {31'b0, e}, 32'h0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: bench hung, got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_bad_start();
        t_start_stop();
        t_prescale();
        t_overflow();
        t_unmapped();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule